// File: doc/BRIEF.md
# Static Memory Bank Controller

This block connects an internal single-request bus to an external asynchronous memory bus of the ROM, SRAM or flash kind. A requester presents one 32-bit read or write with an address. The controller decodes the bank from the upper address bits, drives exactly one active-low chip select, and runs one or more external cycles until the whole word has moved. Each cycle is stretched by the bank's programmed wait count.

Every bank has its own data width of 8, 16 or 32 bits. A word request to a narrow bank is therefore split into several back-to-back external cycles, with the address stepping through the word in ascending order. Two size indicator outputs tell the memory system how wide each transfer is. Reads may be issued as bursts of up to four consecutive words. Inside a burst the chip select stays low, and every external cycle after the first uses a second, shorter wait count.

Configuration is taken from static per-bank inputs. A one-clock `req_ready` pulse ends each request, and `req_err` flags a request whose address selects no bank.

Top module: `static_mem_ctrl`

## Requirements
- R1: The value n of `req_addr[30:28]`, for n from 0 to 5, drives only `ext_cs_n[n]` low for the whole request. At most one chip select is low at any time, and all are high while no request runs.
- R2: A request with `req_addr[30:28]` equal to 6 or 7 runs no external cycle. `req_ready` and `req_err` are both high in the clock after acceptance.
- R3: Each external cycle keeps the chip select and the strobe low for (wait + 1) clocks. The first cycle of every request uses the bank's `cfg_wst` value, and so does every cycle of a request that is not a burst.
- R4: Width code 00 gives an 8-bit bank, 01 a 16-bit bank, and 10 or 11 a 32-bit bank. A word takes 4, 2 or 1 external cycles. `ext_addr` starts at `req_addr[27:0]` with its two low bits cleared and steps up by 1, 2 or 4 per cycle, wrapping within 28 bits.
- R5: In a read, external cycle k of a word supplies byte k from `ext_din[7:0]` (8-bit bank), halfword k from `ext_din[15:0]` (16-bit bank), or the whole word (32-bit bank). `ext_din` is sampled at the clock edge that ends the cycle.
- R6: During a write cycle, `ext_we_n` is low, `ext_oe_n` is high and `ext_dir` is high. `ext_dout` carries byte k or halfword k of `req_wdata` on its low lanes, with the upper lanes zero, or the whole word for a 32-bit bank.
- R7: During a read cycle, `ext_oe_n` is low, `ext_we_n` is high and `ext_dir` is low.
- R8: A read with `req_len` = L transfers L+1 consecutive words with the chip select held low throughout. Every external cycle after the first uses `cfg_bwst`. `rd_valid` pulses, with the word on `rd_data`, in the clock after each word's final cycle.
- R9: A write ignores `req_len` and always transfers exactly one word.
- R10: `req_ready` is a one-clock pulse in the clock right after the final external cycle. All chip selects are high in that clock, and `req_err` is low for a decoded bank.
- R11: `ext_word` is high during 32-bit cycles and `ext_half` during 16-bit cycles. Both are low during byte cycles and while no chip select is low.
- R12: While `rst_n` is low and after it rises, every chip select and both strobes are high, and `req_ready`, `rd_valid`, `ext_word` and `ext_half` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; [30:28] selects the bank |
| req_wdata | input | 32 | Write word |
| req_len | input | 2 | Extra burst words for reads |
| req_ready | output | 1 | One-clock completion pulse |
| req_err | output | 1 | Undecoded bank, valid with `req_ready` |
| rd_data | output | 32 | Read word, valid with `rd_valid` |
| rd_valid | output | 1 | One-clock pulse per read word |
| cfg_width | input | 12 | Width code per bank, two bits each |
| cfg_wst | input | 24 | First-cycle wait count per bank, four bits each |
| cfg_bwst | input | 24 | Burst wait count per bank, four bits each |
| ext_cs_n | output | 6 | Active-low chip selects |
| ext_addr | output | 28 | External byte address |
| ext_dout | output | 32 | External write data |
| ext_din | input | 32 | External read data |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_dir | output | 1 | Transfer direction, 1 = write |
| ext_word | output | 1 | 32-bit transfer indicator |
| ext_half | output | 1 | 16-bit transfer indicator |

## Verification
The bench builds the block with its default parameters: six banks, four-bit wait counts and a two-bit burst length. These values keep every wait count from 0 to 3, every burst wait from 0 to 2, all four width codes, burst lengths of one to four words and both undecoded select values within a sweep of a few hundred requests. Banks rotate through the sweep while the other banks hold different settings, which exposes a wrong per-bank configuration select. A combinational memory model in the bench derives `ext_din` from `ext_addr`, so the expected read word, the address sequence and the exact clock count follow arithmetically from each request.

// File: rtl/smc_pkg.sv
// Shared types and helpers for the static memory bank controller.
// Assumes a 32-bit internal word; width codes are two bits per bank.
package smc_pkg;

    typedef enum logic [1:0] {
        BUS_W8   = 2'b00,
        BUS_W16  = 2'b01,
        BUS_W32  = 2'b10,
        BUS_W32A = 2'b11
    } bus_width_e;

    // log2 of the number of external cycles that one word needs
    function automatic logic [1:0] split_log2(input logic [1:0] code);
        case (bus_width_e'(code))
            BUS_W8:  return 2'd2;
            BUS_W16: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/smc_bank_decode.sv
// Bank select decoder: turns the select field into a one-hot bank vector.
// Assumes NBANK <= 2**SEL_W; codes at or above NBANK give no hit.
module smc_bank_decode #(
    parameter int NBANK = 6,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NBANK-1:0] hit_oh,
    output logic             hit
);

    // one comparator per bank
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        assign hit_oh[i] = (sel == SEL_W'(i));
    end

    assign hit = |hit_oh;

endmodule

// File: rtl/smc_cfg_select.sv
// Per-bank configuration select: AND-OR mux of the static bank settings
// under a one-hot bank vector. Assumes hit_oh is one-hot or zero.
module smc_cfg_select #(
    parameter int NBANK  = 6,
    parameter int WAIT_W = 4
) (
    input  logic [NBANK-1:0]        hit_oh,
    input  logic [2*NBANK-1:0]      cfg_width,
    input  logic [WAIT_W*NBANK-1:0] cfg_wst,
    input  logic [WAIT_W*NBANK-1:0] cfg_bwst,
    output logic [1:0]              width,
    output logic [WAIT_W-1:0]       wst,
    output logic [WAIT_W-1:0]       bwst
);

    // pick the selected bank's fields
    always_comb begin
        width = '0;
        wst   = '0;
        bwst  = '0;
        for (int i = 0; i < NBANK; i++) begin
            width = width | ({2{hit_oh[i]}}      & cfg_width[2*i +: 2]);
            wst   = wst   | ({WAIT_W{hit_oh[i]}} & cfg_wst[WAIT_W*i +: WAIT_W]);
            bwst  = bwst  | ({WAIT_W{hit_oh[i]}} & cfg_bwst[WAIT_W*i +: WAIT_W]);
        end
    end

endmodule

// File: rtl/smc_lane.sv
// Data lane steering: selects the write piece for the current external
// cycle and merges a read piece into the partial word.
// Assumes DW divisible by 4; lg is 2 (bytes), 1 (halves) or 0 (word).
module smc_lane #(
    parameter int DW = 32
) (
    input  logic [1:0]    lg,
    input  logic [1:0]    piece,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] rbuf,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] merged
);

    localparam int HW = DW / 2;
    localparam int BW = DW / 4;

    // steer one piece out and one piece in
    always_comb begin
        dout   = '0;
        merged = rbuf;
        case (lg)
            2'd2: begin
                dout[BW-1:0]            = wdata[int'(piece)*BW +: BW];
                merged[int'(piece)*BW +: BW] = din[BW-1:0];
            end
            2'd1: begin
                dout[HW-1:0]               = wdata[int'(piece[0])*HW +: HW];
                merged[int'(piece[0])*HW +: HW] = din[HW-1:0];
            end
            default: begin
                dout   = wdata;
                merged = din;
            end
        endcase
    end

endmodule

// File: rtl/static_mem_ctrl.sv
// Static memory bank controller top. Accepts one word request at a time,
// decodes the bank, and runs width-split, wait-stretched external cycles.
// Assumes req_* are held stable while req_valid waits for acceptance and
// that cfg_* only change while no request runs.
module static_mem_ctrl
    import smc_pkg::*;
#(
    parameter int NBANK  = 6,
    parameter int AW     = 28,
    parameter int DW     = 32,
    parameter int WAIT_W = 4,
    parameter int LEN_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [AW+3:0]           req_addr,
    input  logic [DW-1:0]           req_wdata,
    input  logic [LEN_W-1:0]        req_len,
    output logic                    req_ready,
    output logic                    req_err,
    output logic [DW-1:0]           rd_data,
    output logic                    rd_valid,
    input  logic [2*NBANK-1:0]      cfg_width,
    input  logic [WAIT_W*NBANK-1:0] cfg_wst,
    input  logic [WAIT_W*NBANK-1:0] cfg_bwst,
    output logic [NBANK-1:0]        ext_cs_n,
    output logic [AW-1:0]           ext_addr,
    output logic [DW-1:0]           ext_dout,
    input  logic [DW-1:0]           ext_din,
    output logic                    ext_oe_n,
    output logic                    ext_we_n,
    output logic                    ext_dir,
    output logic                    ext_word,
    output logic                    ext_half
);

    localparam int SEL_W = 3;

    logic [NBANK-1:0]  hit_oh;
    logic              hit;
    logic [1:0]        sel_width;
    logic [WAIT_W-1:0] sel_wst;
    logic [WAIT_W-1:0] sel_bwst;

    logic              busy_q;
    logic              wr_q;
    logic              burst_q;
    logic [NBANK-1:0]  bank_q;
    logic [1:0]        lg_q;
    logic [WAIT_W-1:0] wst_q;
    logic [WAIT_W-1:0] bwst_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [1:0]        piece_q;
    logic [LEN_W-1:0]  left_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rbuf_q;
    logic [DW-1:0]     rdata_q;
    logic              ready_q;
    logic              err_q;
    logic              rvalid_q;

    logic [DW-1:0]     lane_dout;
    logic [DW-1:0]     lane_merged;
    logic              accept;
    logic              cyc_end;
    logic              word_end;
    logic [1:0]        piece_max;
    logic [AW-1:0]     step;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{req_addr[AW+3], req_addr[1:0]};

    smc_bank_decode #(
        .NBANK (NBANK),
        .SEL_W (SEL_W)
    ) i_decode (
        .sel    (req_addr[AW +: SEL_W]),
        .hit_oh (hit_oh),
        .hit    (hit)
    );

    smc_cfg_select #(
        .NBANK  (NBANK),
        .WAIT_W (WAIT_W)
    ) i_cfg (
        .hit_oh    (hit_oh),
        .cfg_width (cfg_width),
        .cfg_wst   (cfg_wst),
        .cfg_bwst  (cfg_bwst),
        .width     (sel_width),
        .wst       (sel_wst),
        .bwst      (sel_bwst)
    );

    smc_lane #(
        .DW (DW)
    ) i_lane (
        .lg     (lg_q),
        .piece  (piece_q),
        .wdata  (wdata_q),
        .din    (ext_din),
        .rbuf   (rbuf_q),
        .dout   (lane_dout),
        .merged (lane_merged)
    );

    // cycle bookkeeping derived from the current state
    always_comb begin
        accept   = req_valid & ~busy_q & ~ready_q;
        cyc_end  = busy_q & (cnt_q == '0);
        case (lg_q)
            2'd2:    piece_max = 2'd3;
            2'd1:    piece_max = 2'd1;
            default: piece_max = 2'd0;
        endcase
        word_end = cyc_end & (piece_q == piece_max);
        step     = AW'(3'd4 >> lg_q);
    end

    // request sequencer: acceptance, wait counting, piece and beat stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            wr_q     <= 1'b0;
            burst_q  <= 1'b0;
            bank_q   <= '0;
            lg_q     <= '0;
            wst_q    <= '0;
            bwst_q   <= '0;
            cnt_q    <= '0;
            piece_q  <= '0;
            left_q   <= '0;
            addr_q   <= '0;
            ready_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            if (accept) begin
                if (!hit) begin
                    ready_q <= 1'b1;
                    err_q   <= 1'b1;
                end else begin
                    busy_q  <= 1'b1;
                    wr_q    <= req_write;
                    burst_q <= ~req_write & (req_len != '0);
                    bank_q  <= hit_oh;
                    lg_q    <= split_log2(sel_width);
                    wst_q   <= sel_wst;
                    bwst_q  <= sel_bwst;
                    cnt_q   <= sel_wst;
                    piece_q <= '0;
                    left_q  <= req_write ? '0 : req_len;
                    addr_q  <= {req_addr[AW-1:2], 2'b00};
                end
            end else if (busy_q) begin
                if (!cyc_end) begin
                    cnt_q <= cnt_q - WAIT_W'(1);
                end else begin
                    addr_q <= addr_q + step;
                    cnt_q  <= burst_q ? bwst_q : wst_q;
                    if (word_end) begin
                        piece_q <= '0;
                        if (left_q == '0) begin
                            busy_q  <= 1'b0;
                            ready_q <= 1'b1;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                        end
                    end else begin
                        piece_q <= piece_q + 2'd1;
                    end
                end
            end
        end
    end

    // data path registers: write word, read assembly and read output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q  <= '0;
            rbuf_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            if (accept) begin
                wdata_q <= req_wdata;
            end
            if (cyc_end && !wr_q) begin
                rbuf_q <= lane_merged;
                if (word_end) begin
                    rdata_q  <= lane_merged;
                    rvalid_q <= 1'b1;
                end
            end
        end
    end

    // external bus outputs
    always_comb begin
        ext_cs_n = busy_q ? ~bank_q : '1;
        ext_addr = addr_q;
        ext_dout = lane_dout;
        ext_oe_n = ~(busy_q & ~wr_q);
        ext_we_n = ~(busy_q & wr_q);
        ext_dir  = busy_q & wr_q;
        ext_word = busy_q & (lg_q == 2'd0);
        ext_half = busy_q & (lg_q == 2'd1);
    end

    assign req_ready = ready_q;
    assign req_err   = err_q;
    assign rd_data   = rdata_q;
    assign rd_valid  = rvalid_q;

endmodule

// File: rtl/smc_chk.sv
// Protocol checker for static_mem_ctrl, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module smc_chk #(
    parameter int NBANK = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] ext_cs_n,
    input logic             ext_oe_n,
    input logic             ext_we_n,
    input logic             ext_dir,
    input logic             ext_word,
    input logic             ext_half,
    input logic             req_ready,
    input logic             req_err
);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    // R2
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ready);

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R10
    ready_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&ext_cs_n));

    // R7
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> (ext_we_n && !ext_dir && !(&ext_cs_n)));

    // R6
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we_n |-> (ext_dir && !(&ext_cs_n)));

    // R11
    size_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_word || ext_half) |-> (!(ext_word && ext_half) && !(&ext_cs_n)));

endmodule

bind static_mem_ctrl smc_chk #(
    .NBANK (NBANK)
) i_smc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_cs_n  (ext_cs_n),
    .ext_oe_n  (ext_oe_n),
    .ext_we_n  (ext_we_n),
    .ext_dir   (ext_dir),
    .ext_word  (ext_word),
    .ext_half  (ext_half),
    .req_ready (req_ready),
    .req_err   (req_err)
);

// File: tb/test_static_mem_ctrl.sv
`timescale 1ns/1ps
module test_static_mem_ctrl;

    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_len = '0;
    logic        req_ready, req_err, rd_valid;
    logic [31:0] rd_data;
    logic [11:0] cfg_width = '0;
    logic [23:0] cfg_wst = '0;
    logic [23:0] cfg_bwst = '0;
    logic [5:0]  ext_cs_n;
    logic [27:0] ext_addr;
    logic [31:0] ext_dout, ext_din;
    logic        ext_oe_n, ext_we_n, ext_dir, ext_word, ext_half;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // memory model: data is a fixed function of the address
    function automatic logic [31:0] memf(input logic [27:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8], a[7:0] + 8'h33, a[7:0] ^ 8'hC6};
    endfunction

    assign ext_din = memf(ext_addr);

    static_mem_ctrl i_static_mem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_len(req_len),
        .req_ready(req_ready), .req_err(req_err), .rd_data(rd_data), .rd_valid(rd_valid),
        .cfg_width(cfg_width), .cfg_wst(cfg_wst), .cfg_bwst(cfg_bwst),
        .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n), .ext_dir(ext_dir),
        .ext_word(ext_word), .ext_half(ext_half)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pieces_of(input int wcode);
        return (wcode == 0) ? 4 : (wcode == 1) ? 2 : 1;
    endfunction

    // expected word wi of a read starting at the aligned base
    function automatic logic [31:0] exp_word(input logic [27:0] base, input int wi,
                                             input int np);
        logic [31:0] w;
        logic [27:0] b;
        w = '0;
        b = base + 28'(wi * 4);
        for (int k = 0; k < np; k++) begin
            if (np == 4) w[8*k +: 8]   = memf(b + 28'(k))[7:0];
            else if (np == 2) w[16*k +: 16] = memf(b + 28'(2*k))[15:0];
            else w = memf(b);
        end
        return w;
    endfunction

    // give every bank a deliberately different setting, then the target
    task automatic set_cfg(input int bank, input int wcode, input int wt, input int bwt);
        for (int b = 0; b < NB; b++) begin
            cfg_width[2*b +: 2] = 2'((wcode + b + 1) % 3);
            cfg_wst[4*b +: 4]   = 4'(9 + b);
            cfg_bwst[4*b +: 4]  = 4'(7 + b);
        end
        cfg_width[2*bank +: 2] = 2'(wcode);
        cfg_wst[4*bank +: 4]   = 4'(wt);
        cfg_bwst[4*bank +: 4]  = 4'(bwt);
    endtask

    task automatic run_req(input int bank, input int wcode, input int wt, input int bwt,
                           input bit wr, input int len, input logic [27:0] off,
                           input logic [31:0] wd);
        int np, words, total, exp_clk, clocks, cyc, rem, rdn, step;
        bit burst, seen_ready, bad_cs, bad_str, bad_flag, bad_addr, bad_wd, bad_rd;
        logic [31:0] a_act, a_exp, d_act, d_exp, r_act, r_exp, c_act;
        logic [27:0] base, ea;
        logic [31:0] ew;
        set_cfg(bank, wcode, wt, bwt);
        np    = pieces_of(wcode);
        step  = 4 / np;
        words = wr ? 1 : len + 1;
        burst = !wr && (len > 0);
        total = words * np;
        exp_clk = (wt + 1) + (total - 1) * ((burst ? bwt : wt) + 1);
        base  = {off[27:2], 2'b00};
        clocks = 0; cyc = 0; rem = wt + 1; rdn = 0;
        seen_ready = 0; bad_cs = 0; bad_str = 0; bad_flag = 0; bad_addr = 0;
        bad_wd = 0; bad_rd = 0;
        a_act = '0; a_exp = '0; d_act = '0; d_exp = '0; r_act = '0; r_exp = '0;
        c_act = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {1'b0, 3'(bank), off};
        req_wdata = wd;
        req_len   = 2'(len);
        for (int g = 0; g < 400 && !seen_ready; g++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (rd_valid) begin
                ew = exp_word(base, rdn, np);
                if (rd_data !== ew && !bad_rd) begin
                    bad_rd = 1; r_act = rd_data; r_exp = ew;
                end
                rdn++;
            end
            if (req_ready) begin
                seen_ready = 1;
                if (ext_cs_n !== 6'h3F) begin bad_cs = 1; c_act = 32'(ext_cs_n); end
            end else if (ext_cs_n === ~(6'b1 << bank)) begin
                clocks++;
                if (wr ? !(ext_we_n == 0 && ext_oe_n == 1 && ext_dir == 1)
                       : !(ext_oe_n == 0 && ext_we_n == 1 && ext_dir == 0)) bad_str = 1;
                if (ext_word != (np == 1) || ext_half != (np == 2)) bad_flag = 1;
                ea = base + 28'(cyc * step);
                if (ext_addr !== ea && !bad_addr) begin
                    bad_addr = 1; a_act = 32'(ext_addr); a_exp = 32'(ea);
                end
                if (wr) begin
                    if (np == 4) ew = {24'h0, wd[8*(cyc%4) +: 8]};
                    else if (np == 2) ew = {16'h0, wd[16*(cyc%2) +: 16]};
                    else ew = wd;
                    if (ext_dout !== ew && !bad_wd) begin
                        bad_wd = 1; d_act = ext_dout; d_exp = ew;
                    end
                end
                rem--;
                if (rem == 0) begin
                    cyc++;
                    rem = (burst ? bwt : wt) + 1;
                end
            end else if (!bad_cs) begin
                bad_cs = 1; c_act = 32'(ext_cs_n);
            end
        end
        check(!bad_cs, "R1 chip select", c_act, 32'(~(6'b1 << bank)));
        check(!bad_str, wr ? "R6 write strobes" : "R7 read strobes", 32'(bad_str), 0);
        check(!bad_flag, "R11 size indicators", 32'(bad_flag), 0);
        check(!bad_addr && cyc == total, "R4 address sequence", bad_addr ? a_act : 32'(cyc),
              bad_addr ? a_exp : 32'(total));
        if (wr) check(!bad_wd, "R6 write lanes", d_act, d_exp);
        if (wr && len > 0) check(clocks == exp_clk, "R9 write length ignored",
                                 32'(clocks), 32'(exp_clk));
        else if (burst) check(clocks == exp_clk, "R8 burst timing", 32'(clocks), 32'(exp_clk));
        else check(clocks == exp_clk, "R3 wait timing", 32'(clocks), 32'(exp_clk));
        if (!wr) begin
            check(!bad_rd, "R5 read data", r_act, r_exp);
            check(rdn == words, "R8 read word count", 32'(rdn), 32'(words));
        end
        check(seen_ready && !req_err, "R10 ready end", 32'({seen_ready, req_err}), 32'h2);
        @(negedge clk);
        check(!req_ready, "R10 ready pulse width", 32'(req_ready), 0);
    endtask

    task automatic run_err(input int sel, input bit top);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = {top, 3'(sel), 28'h0123450};
        req_len   = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready && req_err && ext_cs_n == 6'h3F && ext_oe_n,
              "R2 undecoded bank", 32'({req_ready, req_err, ext_cs_n}), 32'h0FF);
        @(negedge clk);
        check(!req_ready && ext_cs_n == 6'h3F, "R2 no external cycle",
              32'({req_ready, ext_cs_n}), 32'h3F);
    endtask

    initial begin
        int tx;
        repeat (3) @(negedge clk);
        check(ext_cs_n == 6'h3F && ext_oe_n && ext_we_n && !req_ready && !rd_valid
              && !ext_word && !ext_half, "R12 state in reset",
              32'({ext_cs_n, ext_oe_n, ext_we_n, req_ready, rd_valid, ext_word, ext_half}),
              32'({6'h3F, 1'b1, 1'b1, 4'h0}));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ext_cs_n == 6'h3F && ext_oe_n && ext_we_n && !req_ready && !rd_valid
              && !ext_word && !ext_half, "R12 state after reset",
              32'({ext_cs_n, ext_oe_n, ext_we_n, req_ready, rd_valid, ext_word, ext_half}),
              32'({6'h3F, 1'b1, 1'b1, 4'h0}));
        tx = 0;
        for (int w = 0; w < 4; w++) begin
            for (int wt = 0; wt < 4; wt++) begin
                for (int bwt = 0; bwt < 3; bwt++) begin
                    for (int k = 0; k < 6; k++) begin
                        logic [27:0] off;
                        off = 28'(tx * 32'h01234567 + 32'h0FFFFF0);
                        if (k < 4) run_req(tx % NB, w, wt, bwt, 1'b0, k, off, 32'(tx) * 32'h9E3779B9);
                        else run_req(tx % NB, w, wt, bwt, 1'b1, (k == 4) ? 0 : 3, off,
                                     32'(tx) * 32'h9E3779B9 + 32'h1357);
                        tx++;
                    end
                end
            end
        end
        // address wrap at the top of a bank
        run_req(2, 0, 1, 0, 1'b0, 3, 28'hFFFFFFC, 32'h0);
        run_err(6, 1'b0);
        run_err(7, 1'b0);
        run_err(6, 1'b1);
        run_err(7, 1'b1);
        run_req(5, 1, 2, 1, 1'b0, 1, 28'h0000040, 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule